// File: doc/BRIEF.md
# Block Floating-Point Scaling Controller

This controller decides how far each layer of a mixed-radix transform datapath must shift its results right to avoid overflow. During a layer it watches every complex result the butterfly unit writes and keeps the largest magnitude. Only the four most significant bits of the real and imaginary parts are used for this. When the layer ends, that peak is turned into a headroom figure. The headroom is taken off the worst-case growth of the radix used in the next layer, which gives a right-shift of zero to three bits.

The chosen shifts are added up across the frame into an unsigned block exponent. That exponent goes with the output data as its power-of-two scale. A frame-start pulse clears all of the state. Before the first layer-done pulse of a frame, the samples presented are the raw transform inputs, so the first decision also counts whatever headroom the input data already has.

Top module: `bfp_scale_ctrl`

## Requirements
- R1: After a synchronous reset, `shift_amt` and `blk_exp` are both 0, and the peak tracker is empty.
- R2: Each sample part is reduced to its top 4 bits, bits [17:14] for 18-bit data, read as a signed value t. The magnitude is |t|, so -8 gives 8. The bits below the top four have no effect on any decision.
- R3: The peak is the largest magnitude over all real and imaginary parts presented with `smp_valid` during the layer. A sample presented in the same cycle as `layer_done` counts.
- R4: Headroom is 0 when the peak is 4 or more, 1 when it is 2 or 3, 2 when it is 1, and 3 when it is 0.
- R5: Worst-case growth is selected by `next_radix`. Codes 0 (radix-2), 1 (radix-3) and 2 (first radix-4 layer) give 2 bits. Code 3 (later radix-4 layer), code 4 (radix-5) and the unused codes 5 to 7 give 3 bits.
- R6: In the cycle after `layer_done`, `shift_amt` becomes the worst-case growth minus the headroom, or zero if that difference is negative. It then holds until the next `layer_done` or `frame_start`.
- R7: `blk_exp` increases by the new shift in the same cycle as `shift_amt` is updated. It saturates at 15 and does not change in any cycle without `layer_done`.
- R8: `frame_start` clears the peak, `shift_amt` and `blk_exp`. It takes priority over a `layer_done` or `smp_valid` in the same cycle.
- R9: The peak is cleared when a layer ends, so samples from earlier layers do not affect later decisions.
- R10: Samples presented after `frame_start` and before the first `layer_done` set the first layer's shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Clears the peak, the shift and the exponent |
| smp_valid | input | 1 | A sample is present on `smp_re`/`smp_im` |
| smp_re | input | DATA_W | Real part, two's complement |
| smp_im | input | DATA_W | Imaginary part, two's complement |
| layer_done | input | 1 | The current layer ends this cycle |
| next_radix | input | 3 | Radix code of the next layer (see R5) |
| shift_amt | output | 2 | Registered right-shift for the next layer |
| blk_exp | output | EXP_W | Registered accumulated block exponent |

## Verification
The checker assumes that `frame_start` and `layer_done` are single-cycle strobes sampled on rising edges. It also assumes that the shift and exponent change only in response to those strobes, so its stability properties are written against them alone. The stimulus changes inputs only between edges and asserts each strobe for exactly one cycle. Sample values are chosen so that their top four bits land on each headroom boundary, including the most negative code and a sample that coincides with `layer_done`.

// File: rtl/bfp_scale_pkg.sv
package bfp_scale_pkg;

  typedef enum logic [2:0] {
    RDX2       = 3'd0,
    RDX3       = 3'd1,
    RDX4_FIRST = 3'd2,
    RDX4       = 3'd3,
    RDX5       = 3'd4
  } radix_e;

  localparam int SHIFT_W = 2;

  // worst-case growth in bits of one layer of the given radix
  function automatic logic [SHIFT_W-1:0] worst_shift(input logic [2:0] code);
    case (radix_e'(code))
      RDX2, RDX3, RDX4_FIRST: return 2'd2;
      RDX4, RDX5:             return 2'd3;
      default:                return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/bfp_peak_track.sv
module bfp_peak_track #(
  parameter int DATA_W = 18,
  parameter int MAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              valid,
  input  logic [DATA_W-1:0] re,
  input  logic [DATA_W-1:0] im,
  output logic [MAG_W-1:0]  peak_now
);
  localparam int LANES = 2;

  logic [DATA_W-1:0] lane_in [LANES];
  logic [MAG_W-1:0]  lane_mag [LANES];
  logic [MAG_W-1:0]  peak_q;

  assign lane_in[0] = re;
  assign lane_in[1] = im;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [MAG_W-1:0] top;
    assign top         = lane_in[g][DATA_W-1 -: MAG_W];
    assign lane_mag[g] = top[MAG_W-1] ? (~top + 1'b1) : top;
  end

  always_comb begin
    peak_now = peak_q;
    if (valid) begin
      for (int i = 0; i < LANES; i++)
        if (lane_mag[i] > peak_now) peak_now = lane_mag[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) peak_q <= '0;
    else            peak_q <= peak_now;
  end
endmodule

// File: rtl/bfp_shift_calc.sv
module bfp_shift_calc
  import bfp_scale_pkg::*;
#(
  parameter int MAG_W = 4
) (
  input  logic [MAG_W-1:0]   peak,
  input  logic [2:0]         radix,
  output logic [SHIFT_W-1:0] shift
);
  logic [SHIFT_W-1:0] margin;
  logic [SHIFT_W-1:0] worst;

  always_comb begin
    margin = 2'd3;
    for (int i = 2; i >= 0; i--)
      if (peak >= MAG_W'(1 << (MAG_W - 2 - i))) margin = SHIFT_W'(i);
  end

  assign worst = worst_shift(radix);
  assign shift = (worst > margin) ? (worst - margin) : '0;
endmodule

// File: rtl/bfp_exp_accum.sv
module bfp_exp_accum #(
  parameter int EXP_W   = 4,
  parameter int SHIFT_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               add_en,
  input  logic [SHIFT_W-1:0] add_val,
  output logic [EXP_W-1:0]   exp_q
);
  localparam logic [EXP_W:0] EXP_MAX = {1'b0, {EXP_W{1'b1}}};

  logic [EXP_W:0] sum;
  assign sum = {1'b0, exp_q} + (EXP_W+1)'(add_val);

  always_ff @(posedge clk) begin
    if (rst || clr)  exp_q <= '0;
    else if (add_en) exp_q <= (sum > EXP_MAX) ? EXP_MAX[EXP_W-1:0] : sum[EXP_W-1:0];
  end
endmodule

// File: rtl/bfp_scale_ctrl.sv
module bfp_scale_ctrl
  import bfp_scale_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int MAG_W  = 4,
  parameter int EXP_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_re,
  input  logic [DATA_W-1:0] smp_im,
  input  logic              layer_done,
  input  logic [2:0]        next_radix,
  output logic [1:0]        shift_amt,
  output logic [EXP_W-1:0]  blk_exp
);
  logic [MAG_W-1:0]   peak_now;
  logic [SHIFT_W-1:0] shift_next;
  logic               take;

  assign take = layer_done && !frame_start;

  bfp_peak_track #(.DATA_W(DATA_W), .MAG_W(MAG_W)) u_peak (
    .clk(clk), .rst(rst), .clr(frame_start || layer_done),
    .valid(smp_valid), .re(smp_re), .im(smp_im), .peak_now(peak_now)
  );

  bfp_shift_calc #(.MAG_W(MAG_W)) u_calc (
    .peak(peak_now), .radix(next_radix), .shift(shift_next)
  );

  bfp_exp_accum #(.EXP_W(EXP_W), .SHIFT_W(SHIFT_W)) u_acc (
    .clk(clk), .rst(rst), .clr(frame_start), .add_en(take),
    .add_val(shift_next), .exp_q(blk_exp)
  );

  always_ff @(posedge clk) begin
    if (rst || frame_start) shift_amt <= '0;
    else if (take)          shift_amt <= shift_next;
  end
endmodule

// File: rtl/bfp_scale_ctrl_chk.sv
module bfp_scale_ctrl_chk #(
  parameter int EXP_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_start,
  input logic             layer_done,
  input logic [2:0]       next_radix,
  input logic [1:0]       shift_amt,
  input logic [EXP_W-1:0] blk_exp
);
  localparam logic [EXP_W-1:0] TOP = {EXP_W{1'b1}};

  AST_FRAME_CLEAR: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (blk_exp == '0 && shift_amt == '0)); // R8

  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!frame_start && !layer_done) |=> $stable(shift_amt)); // R6

  AST_EXP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!frame_start && !layer_done) |=> $stable(blk_exp)); // R7

  AST_EXP_MONOTONE: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> blk_exp >= $past(blk_exp)); // R7

  AST_EXP_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (blk_exp == TOP && !frame_start) |=> blk_exp == TOP); // R7

  AST_SHIFT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (layer_done && !frame_start && next_radix <= 3'd2) |=> shift_amt <= 2'd2); // R5

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (blk_exp == '0 && shift_amt == '0)); // R1
endmodule

bind bfp_scale_ctrl bfp_scale_ctrl_chk #(.EXP_W(EXP_W)) u_chk (
  .clk(clk), .rst(rst), .frame_start(frame_start), .layer_done(layer_done),
  .next_radix(next_radix), .shift_amt(shift_amt), .blk_exp(blk_exp)
);

// File: tb/sim_bfp_scale_ctrl.sv
`timescale 1ns/1ps
module sim_bfp_scale_ctrl;
  localparam int DATA_W = 18;
  localparam int EXP_W  = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              frame_start = 1'b0;
  logic              smp_valid = 1'b0;
  logic [DATA_W-1:0] smp_re = '0;
  logic [DATA_W-1:0] smp_im = '0;
  logic              layer_done = 1'b0;
  logic [2:0]        next_radix = '0;
  logic [1:0]        shift_amt;
  logic [EXP_W-1:0]  blk_exp;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bfp_scale_ctrl #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u0 (
    .clk(clk), .rst(rst), .frame_start(frame_start), .smp_valid(smp_valid),
    .smp_re(smp_re), .smp_im(smp_im), .layer_done(layer_done),
    .next_radix(next_radix), .shift_amt(shift_amt), .blk_exp(blk_exp)
  );

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [DATA_W-1:0] re, input logic [DATA_W-1:0] im);
    smp_valid = 1'b1; smp_re = re; smp_im = im;
    cyc();
    smp_valid = 1'b0; smp_re = '0; smp_im = '0;
  endtask

  task automatic new_frame();
    frame_start = 1'b1;
    cyc();
    frame_start = 1'b0;
  endtask

  task automatic end_layer(input logic [2:0] code, input bit with_smp,
                           input logic [DATA_W-1:0] re, input logic [DATA_W-1:0] im);
    layer_done = 1'b1; next_radix = code;
    smp_valid = with_smp; smp_re = re; smp_im = im;
    cyc();
    layer_done = 1'b0; smp_valid = 1'b0; smp_re = '0; smp_im = '0;
  endtask

  task automatic t_reset();
    chk("R1 shift after reset", shift_amt, 0);
    chk("R1 exp after reset", blk_exp, 0);
  endtask

  task automatic t_first_layer();
    new_frame();
    push(18'h0C000, 18'h03FFF);          // top 3 -> headroom 1
    end_layer(3'd2, 1'b0, '0, '0);       // first radix-4: 2 - 1
    chk("R10 first layer shift", shift_amt, 1);
    chk("R7 exp after first layer", blk_exp, 1);
  endtask

  task automatic t_low_bits();
    push(18'h03FFF, 18'h03FFF);          // top 0, low bits ignored
    end_layer(3'd4, 1'b0, '0, '0);       // radix-5: 3 - 3
    chk("R2 low bits ignored shift", shift_amt, 0);
    chk("R4 exp unchanged", blk_exp, 1);
  endtask

  task automatic t_peak_on_done();
    push(18'h04000, 18'h00000);
    push(18'h00000, 18'h38000);          // -2 -> 2
    end_layer(3'd4, 1'b1, 18'h20000, '0); // -8 -> 8, headroom 0
    chk("R3 peak includes done sample", shift_amt, 3);
    chk("R7 exp accumulate", blk_exp, 4);
  endtask

  task automatic t_peak_cleared();
    push(18'h3C000, 18'h00000);          // -1 -> 1, headroom 2
    end_layer(3'd1, 1'b0, '0, '0);       // radix-3: 2 - 2
    chk("R9 peak cleared between layers", shift_amt, 0);
    chk("R5 radix-3 exp", blk_exp, 4);
    push(18'h04000, 18'h00000);          // headroom 2
    end_layer(3'd3, 1'b0, '0, '0);       // later radix-4: 3 - 2
    chk("R5 later radix-4 shift", shift_amt, 1);
    chk("R6 exp after radix-4", blk_exp, 5);
    repeat (3) cyc();
    chk("R6 shift held", shift_amt, 1);
    chk("R7 exp held", blk_exp, 5);
  endtask

  task automatic t_saturate();
    new_frame();
    chk("R8 frame clears exp", blk_exp, 0);
    chk("R8 frame clears shift", shift_amt, 0);
    for (int i = 0; i < 6; i++) begin
      push(18'h1FFFF, 18'h00000);        // 7 -> headroom 0
      end_layer(3'd4, 1'b0, '0, '0);
      if (i == 3) chk("R7 exp before saturation", blk_exp, 12);
    end
    chk("R7 exp saturates", blk_exp, 15);
    chk("R6 shift radix-5 full", shift_amt, 3);
  endtask

  task automatic t_priority();
    push(18'h20000, 18'h00000);
    frame_start = 1'b1;
    end_layer(3'd4, 1'b1, 18'h20000, 18'h20000);
    frame_start = 1'b0;
    chk("R8 frame beats layer exp", blk_exp, 0);
    chk("R8 frame beats layer shift", shift_amt, 0);
    end_layer(3'd0, 1'b0, '0, '0);       // empty peak: 2 - 3 -> 0
    chk("R8 peak cleared by frame", shift_amt, 0);
    chk("R8 exp after empty layer", blk_exp, 0);
  endtask

  initial begin
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    t_reset();
    t_first_layer();
    t_low_bits();
    t_peak_on_done();
    t_peak_cleared();
    t_saturate();
    t_priority();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule